// File: doc/BRIEF.md
# Reset-Time Fetch Hold Controller

This block decides when a processor core may issue its first instruction fetch after reset. An active-low halt pin is sampled as reset is released. If the pin is low at that point, the core stays parked with no fetch outstanding. During that window an external agent can write the core's local memory through a slave write path, for example to load boot code. When the pin goes high, the block raises a single fetch request for the reset vector and holds it until the core pipeline acknowledges it. After that the core runs, and the block has no further say over fetching.

The hold works as a one-shot latch, not as a live stall. Once the launch has begun, the halt pin is ignored. Only a new reset arms the hold again. The pin and the reset release each pass through a clocked synchronizer.

Three strap inputs are sampled in the same cycle that the block leaves its reset state:
- the local memory enable,
- the base address of the local memory window,
- the choice between a low and a high reset vector.

They stay fixed until the next reset.

Top module: `fetch_hold_ctrl`

## Requirements
- R1: While `rst_ni` is low and until the release has passed the reset synchronizer, `core_state_o` reads 2'b00 (in reset), `fetch_req_o` and `lmem_wr_o` are 0, and `lmem_en_o` and `lmem_base_o` are 0.
- R2: If the synchronized halt pin is low on the clock edge that completes reset release, `core_state_o` becomes 2'b01 (held), and `fetch_req_o` stays 0 for as long as the pin stays low.
- R3: A rising halt pin in the held state raises `fetch_req_o` after SYNC_STAGES+1 clock edges, and `core_state_o` reads 2'b10 (running) from then on.
- R4: Once the launch has begun, driving the halt pin low again changes neither `core_state_o` nor `fetch_req_o`.
- R5: A new reset arms the hold again: with the pin low at that release, the core returns to the held state.
- R6: `fetch_req_o` and `fetch_addr_o` stay stable until a clock edge sees `fetch_ack_i` high. From the next cycle on, `fetch_req_o` is 0 for good.
- R7: `fetch_addr_o` equals LO_VEC when `strap_hivec_i` was 0 at release and HI_VEC when it was 1. Later changes of that strap have no effect.
- R8: `lmem_en_o` and `lmem_base_o` take the values of `strap_lmem_en_i` and `strap_lmem_base_i` at the release edge and ignore later changes of those straps.
- R9: Outside reset (held or running), `lmem_wr_o` is 1 exactly when `slv_wr_i` is 1, the local memory is enabled, and `slv_addr_i[ADDR_W-1:LMEM_AW]` equals `lmem_base_o`. `lmem_addr_o` carries `slv_addr_i[LMEM_AW-1:0]`.
- R10: With the pin high at release, the request rises on the release edge itself, with no held cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| halt_ni | input | 1 | Active-low fetch hold pin, asynchronous |
| strap_lmem_en_i | input | 1 | Local memory enable strap |
| strap_lmem_base_i | input | ADDR_W-LMEM_AW | Local memory window base strap (upper address bits) |
| strap_hivec_i | input | 1 | 1 selects HI_VEC, 0 selects LO_VEC |
| fetch_req_o | output | 1 | First fetch request toward the pipeline |
| fetch_addr_o | output | ADDR_W | Reset vector address of that fetch |
| fetch_ack_i | input | 1 | Pipeline accepts the fetch request |
| slv_wr_i | input | 1 | Slave write strobe |
| slv_addr_i | input | ADDR_W | Slave write address |
| lmem_wr_o | output | 1 | Write strobe into local memory |
| lmem_addr_o | output | LMEM_AW | Offset inside local memory |
| lmem_en_o | output | 1 | Captured local memory enable |
| lmem_base_o | output | ADDR_W-LMEM_AW | Captured local memory base |
| core_state_o | output | 2 | 00 in reset, 01 held, 10 running |

## Verification
The bench holds the pin low through release, preloads, then releases the pin while withholding the acknowledge for several cycles. A design that latched the pin too late, or never at all, would fetch during preload; one that did not hold the request would lose the vector. After the launch it pulses the pin low. A design that treats the pin as a live stall would drop back to held or raise a second request. It also changes every strap after release and writes both inside and outside the window. A design that samples straps continuously would move the window or the vector. Finally, it resets in the middle of a run to show that the hold is armed again, and it releases with the pin already high to show that no held cycle is inserted.

// File: rtl/fhc_pkg.sv
package fhc_pkg;

  typedef enum logic [1:0] {
    SEQ_RESET  = 2'd0,
    SEQ_HELD   = 2'd1,
    SEQ_LAUNCH = 2'd2,
    SEQ_RUN    = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    CORE_IN_RESET = 2'b00,
    CORE_HELD     = 2'b01,
    CORE_RUNNING  = 2'b10
  } core_status_e;

  function automatic core_status_e status_of(seq_state_e s);
    case (s)
      SEQ_RESET:  return CORE_IN_RESET;
      SEQ_HELD:   return CORE_HELD;
      default:    return CORE_RUNNING;
    endcase
  endfunction

endpackage

// File: rtl/fhc_sync.sv
// Multi-stage synchronizer with an asynchronous clear to RST_VAL.
module fhc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = d_i;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/fhc_seq.sv
// Launch sequencer: reset -> held/launch -> run, one way only.
module fhc_seq
  import fhc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rel_i,
  input  logic       go_i,
  input  logic       ack_i,
  output seq_state_e state_o,
  output logic       capture_o
);

  seq_state_e state_q;
  seq_state_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      SEQ_RESET: begin
        if (rel_i) begin
          state_d = go_i ? SEQ_LAUNCH : SEQ_HELD;
        end
      end
      SEQ_HELD: begin
        if (go_i) begin
          state_d = SEQ_LAUNCH;
        end
      end
      SEQ_LAUNCH: begin
        if (ack_i) begin
          state_d = SEQ_RUN;
        end
      end
      SEQ_RUN: begin
        state_d = SEQ_RUN;
      end
      default: begin
        state_d = SEQ_RESET;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_RESET;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o   = state_q;
  assign capture_o = (state_q == SEQ_RESET) && rel_i;

endmodule

// File: rtl/fhc_strap_latch.sv
// Holds the strap values captured on the release edge.
module fhc_strap_latch #(
  parameter int BASE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              lmem_en_i,
  input  logic [BASE_W-1:0] lmem_base_i,
  input  logic              hivec_i,
  output logic              lmem_en_o,
  output logic [BASE_W-1:0] lmem_base_o,
  output logic              hivec_o
);

  logic              en_q,   en_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic              hi_q,   hi_d;

  always_comb begin
    en_d   = en_q;
    base_d = base_q;
    hi_d   = hi_q;
    if (load_i) begin
      en_d   = lmem_en_i;
      base_d = lmem_base_i;
      hi_d   = hivec_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      base_q <= '0;
      hi_q   <= 1'b0;
    end else begin
      en_q   <= en_d;
      base_q <= base_d;
      hi_q   <= hi_d;
    end
  end

  assign lmem_en_o   = en_q;
  assign lmem_base_o = base_q;
  assign hivec_o     = hi_q;

endmodule

// File: rtl/fhc_lmem_decode.sv
// Routes slave writes that fall inside the local memory window.
module fhc_lmem_decode #(
  parameter int ADDR_W  = 32,
  parameter int LMEM_AW = 16,
  localparam int BASE_W = ADDR_W - LMEM_AW
) (
  input  logic               en_i,
  input  logic [BASE_W-1:0]  base_i,
  input  logic               active_i,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               wr_o,
  output logic [LMEM_AW-1:0] offs_o
);

  logic hit;

  assign hit    = (addr_i[ADDR_W-1:LMEM_AW] == base_i);
  assign wr_o   = wr_i && en_i && active_i && hit;
  assign offs_o = addr_i[LMEM_AW-1:0];

endmodule

// File: rtl/fetch_hold_ctrl.sv
module fetch_hold_ctrl
  import fhc_pkg::*;
#(
  parameter int              ADDR_W      = 32,
  parameter int              LMEM_AW     = 16,
  parameter int              SYNC_STAGES = 2,
  parameter int              RST_STAGES  = 2,
  parameter logic [ADDR_W-1:0] LO_VEC    = 32'h0000_0000,
  parameter logic [ADDR_W-1:0] HI_VEC    = 32'hFFFF_0000,
  localparam int             BASE_W      = ADDR_W - LMEM_AW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               halt_ni,
  input  logic               strap_lmem_en_i,
  input  logic [BASE_W-1:0]  strap_lmem_base_i,
  input  logic               strap_hivec_i,
  output logic               fetch_req_o,
  output logic [ADDR_W-1:0]  fetch_addr_o,
  input  logic               fetch_ack_i,
  input  logic               slv_wr_i,
  input  logic [ADDR_W-1:0]  slv_addr_i,
  output logic               lmem_wr_o,
  output logic [LMEM_AW-1:0] lmem_addr_o,
  output logic               lmem_en_o,
  output logic [BASE_W-1:0]  lmem_base_o,
  output logic [1:0]         core_state_o
);

  logic       rel;
  logic       go;
  logic       capture;
  logic       hivec;
  seq_state_e state;

  // Reset release passes through its own synchronizer.
  fhc_sync #(.STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rel_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (1'b1),
    .q_o   (rel)
  );

  // Halt pin clears to "held" so reset never looks like a release.
  fhc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_halt_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (halt_ni),
    .q_o   (go)
  );

  fhc_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rel_i    (rel),
    .go_i     (go),
    .ack_i    (fetch_ack_i),
    .state_o  (state),
    .capture_o(capture)
  );

  fhc_strap_latch #(.BASE_W(BASE_W)) u_straps (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (capture),
    .lmem_en_i  (strap_lmem_en_i),
    .lmem_base_i(strap_lmem_base_i),
    .hivec_i    (strap_hivec_i),
    .lmem_en_o  (lmem_en_o),
    .lmem_base_o(lmem_base_o),
    .hivec_o    (hivec)
  );

  fhc_lmem_decode #(.ADDR_W(ADDR_W), .LMEM_AW(LMEM_AW)) u_decode (
    .en_i    (lmem_en_o),
    .base_i  (lmem_base_o),
    .active_i(state != SEQ_RESET),
    .wr_i    (slv_wr_i),
    .addr_i  (slv_addr_i),
    .wr_o    (lmem_wr_o),
    .offs_o  (lmem_addr_o)
  );

  assign fetch_req_o  = (state == SEQ_LAUNCH);
  assign fetch_addr_o = hivec ? HI_VEC : LO_VEC;
  assign core_state_o = status_of(state);

endmodule

// File: rtl/fhc_checker.sv
module fhc_checker #(
  parameter int ADDR_W  = 32,
  parameter int BASE_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_req_o,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic              fetch_ack_i,
  input logic              slv_wr_i,
  input logic              lmem_wr_o,
  input logic              lmem_en_o,
  input logic [BASE_W-1:0] lmem_base_o,
  input logic [1:0]        core_state_o
);

  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_state_o == 2'b00) |-> (!fetch_req_o && !lmem_wr_o));

  p_held_no_fetch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_state_o == 2'b01) |-> !fetch_req_o);

  p_status_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_state_o != 2'b11);

  p_run_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_state_o == 2'b10) |=> (core_state_o == 2'b10));

  p_no_refetch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_state_o == 2'b10 && !fetch_req_o) |=> !fetch_req_o);

  p_req_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_o && !fetch_ack_i) |=> (fetch_req_o && $stable(fetch_addr_o)));

  p_req_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_o && fetch_ack_i) |=> !fetch_req_o);

  p_vec_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_state_o != 2'b00) |=> $stable(fetch_addr_o));

  p_straps_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_state_o != 2'b00) |=> ($stable(lmem_en_o) && $stable(lmem_base_o)));

  p_wr_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lmem_wr_o |-> (slv_wr_i && lmem_en_o && core_state_o != 2'b00));

endmodule

bind fetch_hold_ctrl fhc_checker #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_fhc_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fetch_req_o (fetch_req_o),
  .fetch_addr_o(fetch_addr_o),
  .fetch_ack_i (fetch_ack_i),
  .slv_wr_i    (slv_wr_i),
  .lmem_wr_o   (lmem_wr_o),
  .lmem_en_o   (lmem_en_o),
  .lmem_base_o (lmem_base_o),
  .core_state_o(core_state_o)
);

// File: tb/test_fetch_hold_ctrl.sv
module test_fetch_hold_ctrl;

  localparam logic [31:0] LO = 32'h0000_0000;
  localparam logic [31:0] HI = 32'hFFFF_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        halt_n;
  logic        s_en;
  logic [15:0] s_base;
  logic        s_hi;
  logic        req;
  logic [31:0] faddr;
  logic        ack;
  logic        swr;
  logic [31:0] saddr;
  logic        lwr;
  logic [15:0] laddr;
  logic        len;
  logic [15:0] lbase;
  logic [1:0]  cstate;

  always #4 clk = ~clk;

  fetch_hold_ctrl i_fetch_hold_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .halt_ni(halt_n),
    .strap_lmem_en_i(s_en), .strap_lmem_base_i(s_base), .strap_hivec_i(s_hi),
    .fetch_req_o(req), .fetch_addr_o(faddr), .fetch_ack_i(ack),
    .slv_wr_i(swr), .slv_addr_i(saddr), .lmem_wr_o(lwr), .lmem_addr_o(laddr),
    .lmem_en_o(len), .lmem_base_o(lbase), .core_state_o(cstate)
  );

  int cyc_vec = 0, cyc_miss = 0;
  int dir_vec = 0, dir_miss = 0;
  int wd_cycles = 0;
  bit done = 1'b0;

  // Behavioural reference: cycles since release, pin history, phase.
  int          m_rel;
  bit          m_p1, m_p2;
  int          m_phase;      // 0 reset, 1 held, 2 launching, 3 running
  bit          m_en;
  bit   [15:0] m_base;
  bit          m_hi;

  task automatic chk_cyc(string tag, logic [31:0] act, logic [31:0] exp);
    cyc_vec++;
    if (act !== exp) begin
      cyc_miss++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_dir(string tag, logic [31:0] act, logic [31:0] exp);
    dir_vec++;
    if (act !== exp) begin
      dir_miss++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit old_rel, old_go;
    if (!rst_n) begin
      m_rel = 0; m_p1 = 0; m_p2 = 0; m_phase = 0;
      m_en = 0; m_base = '0; m_hi = 0;
    end else begin
      old_rel = (m_rel >= 2);
      old_go  = m_p2;
      if (m_phase == 0 && old_rel) begin
        m_en = s_en; m_base = s_base; m_hi = s_hi;
        m_phase = old_go ? 2 : 1;
      end else if (m_phase == 1 && old_go) begin
        m_phase = 2;
      end else if (m_phase == 2 && ack) begin
        m_phase = 3;
      end
      m_p2 = m_p1;
      m_p1 = halt_n;
      if (m_rel < 2) m_rel++;
    end
    #3;
    if (!done) begin
      chk_cyc(m_phase == 0 ? "R1" : "R2", {30'd0, cstate},
              m_phase == 0 ? 32'd0 : (m_phase == 1 ? 32'd1 : 32'd2));
      chk_cyc("R3", {31'd0, req}, {31'd0, m_phase == 2});
      chk_cyc("R7", faddr, m_hi ? HI : LO);
      chk_cyc("R8", {15'd0, len, lbase}, {15'd0, m_en, m_base});
      chk_cyc("R9", {31'd0, lwr},
              {31'd0, swr && m_en && m_phase != 0 && saddr[31:16] == m_base});
      chk_cyc("R9", {16'd0, laddr}, {16'd0, saddr[15:0]});
    end
  end

  function automatic void summary();
    $display("== %0d vectors applied, %0d miscompares ==",
             cyc_vec + dir_vec, cyc_miss + dir_miss + (wd_cycles > 20000 ? 1 : 0));
  endfunction

  always @(posedge clk) begin
    wd_cycles++;
    if (wd_cycles > 20000 && !done) begin
      done = 1'b1;
      $display("FAIL R1 watchdog: cycles %0d expected at most %0d", wd_cycles, 20000);
      summary();
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; halt_n = 0; s_en = 1; s_base = 16'h0010; s_hi = 0;
    ack = 0; swr = 0; saddr = '0;

    // Reset with hold pin low
    tick(4);
    swr = 1; saddr = 32'h0010_0008;
    tick(1);
    chk_dir("R1", {30'd0, cstate}, 32'd0);
    chk_dir("R1", {31'd0, lwr}, 32'd0);
    swr = 0;
    rst_n = 1;
    tick(8);
    chk_dir("R2", {30'd0, cstate}, 32'd1);
    chk_dir("R2", {31'd0, req}, 32'd0);
    // preload during hold; straps moved afterwards
    s_base = 16'h0077; s_en = 0; s_hi = 1;
    swr = 1; saddr = 32'h0010_0040;
    tick(1);
    chk_dir("R9", {31'd0, lwr}, 32'd1);
    chk_dir("R9", {16'd0, laddr}, 32'h0040);
    saddr = 32'h0077_0040;
    tick(1);
    chk_dir("R8", {16'd0, lbase}, 32'h0010);
    chk_dir("R9", {31'd0, lwr}, 32'd0);
    swr = 0;
    // release pin, hold off the acknowledge
    halt_n = 1;
    tick(2);
    chk_dir("R3", {31'd0, req}, 32'd0);
    tick(1);
    chk_dir("R3", {31'd0, req}, 32'd1);
    chk_dir("R7", faddr, LO);
    tick(4);
    chk_dir("R6", {31'd0, req}, 32'd1);
    ack = 1;
    tick(1);
    ack = 0;
    chk_dir("R6", {31'd0, req}, 32'd0);
    chk_dir("R6", {30'd0, cstate}, 32'd2);
    // pin pulsed low while running
    halt_n = 0;
    tick(6);
    halt_n = 1;
    tick(4);
    chk_dir("R4", {30'd0, cstate}, 32'd2);
    chk_dir("R4", {31'd0, req}, 32'd0);
    swr = 1; saddr = 32'h0010_1234;
    tick(1);
    chk_dir("R9", {31'd0, lwr}, 32'd1);
    swr = 0;

    // Reset mid-run with pin low: hold armed again
    halt_n = 0; s_en = 1; s_base = 16'h8000; s_hi = 0;
    rst_n = 0;
    tick(1);
    chk_dir("R1", {30'd0, cstate}, 32'd0);
    chk_dir("R1", {15'd0, len, lbase}, 32'd0);
    tick(3);
    rst_n = 1;
    tick(6);
    chk_dir("R5", {30'd0, cstate}, 32'd1);
    chk_dir("R8", {15'd0, len, lbase}, {15'd0, 1'b1, 16'h8000});
    halt_n = 1; ack = 1;
    tick(5);
    chk_dir("R5", {30'd0, cstate}, 32'd2);
    ack = 0;

    // Reset with pin high and high vector, memory disabled
    halt_n = 1; s_en = 0; s_base = 16'h0002; s_hi = 1;
    rst_n = 0;
    tick(4);
    rst_n = 1;
    tick(3);
    chk_dir("R10", {31'd0, req}, 32'd1);
    chk_dir("R10", {30'd0, cstate}, 32'd2);
    chk_dir("R7", faddr, HI);
    s_hi = 0;
    swr = 1; saddr = 32'h0002_0010;
    tick(1);
    chk_dir("R9", {31'd0, lwr}, 32'd0);
    chk_dir("R7", faddr, HI);
    swr = 0; ack = 1;
    tick(1);
    ack = 0;
    chk_dir("R6", {31'd0, req}, 32'd0);
    tick(3);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule